// File: doc/BRIEF.md
# PRBS-11 Bit Error Rate Tester

This block sits behind a demodulator and measures the bit error rate of a received stream that is expected to carry the 2047-bit PRBS-11 test pattern. A fixed correlator watches the stream for the leading bits of the sequence and flags the moment the pattern's start goes by. In parallel, a self-synchronizing acquisition stage predicts each incoming bit from the eleven bits before it. After a long enough run of correct predictions, it locks a local PRBS-11 generator, which then free-runs.

While locked, every received bit is compared with the local generator. Errors are gathered in 8-bit groups, and any group that holds an error raises a one-cycle byte-error pulse. Errors are also totalled over consecutive windows of 10,000 bits. At the end of each window the total is published on a held count output with a one-cycle strobe. A window with too many errors means the lock was false or the link is gone: the tester drops sync and hunts again.

Top module: `prbs11_bert`

## Requirements
- R1: The reference sequence obeys x^11 + x^9 + 1: each bit equals the XOR of the bits received 11 and 9 positions earlier, so a clean PRBS-11 stream, once locked, yields zero errors.
- R2: `seq_start` pulses for one cycle, in the cycle after the accepted bit that completes the 24-bit opening of the sequence. That opening is the first 24 generator outputs starting from the all-ones state (nine 0s first), oldest bit first.
- R3: While hunting, a bit matches when the preceding 11 received bits are not all zero and the bit equals their predicted value. `sync` rises in the cycle after the 64th consecutive match, and any non-matching bit restarts the run.
- R4: An all-zero input stream never brings `sync` high.
- R5: While locked, the local generator advances on its own output, not on the received bits. A flipped received bit therefore counts as exactly one error.
- R6: While locked, `byte_err` pulses for one cycle after every 8th compared bit if any of those 8 bits was wrong. Groups start with the first bit after `sync` rises, and no pulse occurs while unlocked.
- R7: While locked, bits are counted in windows of 10,000. After the last bit of a window, `ber_count` takes that window's error total and `ber_upd` pulses for one cycle. `ber_count` holds its value at all other times.
- R8: A window with more than 2,000 errors drops `sync` in the same cycle as its `ber_upd`, and hunting restarts. A window with exactly 2,000 errors keeps the lock.
- R9: A cycle with `bit_vld` low advances nothing: no pulse appears on any output, and the count, windows and lock stay as they are.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Received bit |
| sync | output | 1 | Locked to the received sequence |
| seq_start | output | 1 | One-cycle pulse: sequence opening detected |
| byte_err | output | 1 | One-cycle pulse: the last 8-bit group held an error |
| ber_upd | output | 1 | One-cycle strobe: `ber_count` updated |
| ber_count | output | 16 | Error total of the last completed window |

## Verification
The bench first feeds a long all-zero stream; a design that skipped the all-zero guard would lock onto nothing. It runs windows with exactly 2,000 and then 2,500 errors. An off-by-one comparison would either drop a lock it should keep or keep one it should drop. Errors are placed so that two fall in one byte, which catches a byte flag that counts errors instead of groups, or a generator that resynchronizes on received data and turns one flipped bit into a burst. Idle cycles are scattered through a window to expose counters that advance without a valid bit, and a re-acquisition after loss shows whether the hunt state is properly restored.

// File: rtl/prbs11_bert_pkg.sv
package prbs11_bert_pkg;

  localparam int PRBS_ORDER = 11;
  localparam int GROUP_BITS = 8;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_st_e;

  // next sequence bit from the last 11 bits (bit 0 newest): x^11 + x^9 + 1
  function automatic logic prbs_fb(input logic [PRBS_ORDER-1:0] h);
    return h[10] ^ h[8];
  endfunction

  // first n generator outputs from the all-ones state, oldest bit at n-1
  function automatic logic [63:0] lead_pattern(input int n);
    logic [PRBS_ORDER-1:0] s;
    logic [63:0]           p;
    logic                  b;
    s = '1;
    p = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < n) begin
        b = prbs_fb(s);
        s = {s[PRBS_ORDER-2:0], b};
        p[n-1-i] = b;
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/prbs11_start_corr.sv
module prbs11_start_corr
  import prbs11_bert_pkg::*;
#(
  parameter int CORR_LEN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit
);

  localparam logic [63:0] REF64 = lead_pattern(CORR_LEN);

  logic [CORR_LEN-1:0] win_q, win_d;
  logic                hit_q, hit_d;

  always_comb begin
    win_d = win_q;
    hit_d = 1'b0;
    if (bit_vld) begin
      win_d = {win_q[CORR_LEN-2:0], bit_in};
      hit_d = (win_d == REF64[CORR_LEN-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      hit_q <= 1'b0;
    end else begin
      win_q <= win_d;
      hit_q <= hit_d;
    end
  end

  assign hit = hit_q;

endmodule

// File: rtl/prbs11_lock_ctrl.sv
module prbs11_lock_ctrl
  import prbs11_bert_pkg::*;
#(
  parameter int SYNC_RUN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic drop,
  output logic in_sync,
  output logic cmp_vld,
  output logic cmp_err
);

  localparam int RUN_W = $clog2(SYNC_RUN + 1);

  lock_st_e               st_q, st_d;
  logic [PRBS_ORDER-1:0]  hist_q, hist_d;
  logic [RUN_W-1:0]       run_q, run_d;
  logic                   pred;
  logic                   match;

  assign pred  = prbs_fb(hist_q);
  assign match = (hist_q != '0) && (bit_in == pred);

  always_comb begin
    st_d    = st_q;
    hist_d  = hist_q;
    run_d   = run_q;
    cmp_vld = bit_vld && (st_q == ST_LOCK);
    cmp_err = bit_in ^ pred;
    if (bit_vld) begin
      case (st_q)
        ST_HUNT: begin
          hist_d = {hist_q[PRBS_ORDER-2:0], bit_in};
          if (!match) begin
            run_d = '0;
          end else if (run_q == RUN_W'(SYNC_RUN - 1)) begin
            run_d = '0;
            st_d  = ST_LOCK;
          end else begin
            run_d = run_q + RUN_W'(1);
          end
        end
        default: begin
          hist_d = {hist_q[PRBS_ORDER-2:0], pred};
          if (drop) begin
            st_d  = ST_HUNT;
            run_d = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      hist_q <= '0;
      run_q  <= '0;
    end else begin
      st_q   <= st_d;
      hist_q <= hist_d;
      run_q  <= run_d;
    end
  end

  assign in_sync = (st_q == ST_LOCK);

endmodule

// File: rtl/prbs11_err_meter.sv
module prbs11_err_meter
  import prbs11_bert_pkg::*;
#(
  parameter int WIN_BITS  = 10000,
  parameter int ERR_LIMIT = 2000,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_sync,
  input  logic             cmp_vld,
  input  logic             cmp_err,
  output logic             drop,
  output logic             byte_err,
  output logic             ber_upd,
  output logic [CNT_W-1:0] ber_count
);

  localparam int BIT_W = $clog2(WIN_BITS);
  localparam int PH_W  = $clog2(GROUP_BITS);

  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CNT_W-1:0] err_q, err_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             any_q, any_d;
  logic             berr_q, berr_d;
  logic             upd_q, upd_d;
  logic [CNT_W-1:0] err_sum;
  logic             any_now;
  logic             last_bit;

  assign err_sum  = err_q + CNT_W'(cmp_err);
  assign any_now  = any_q | cmp_err;
  assign last_bit = (bit_q == BIT_W'(WIN_BITS - 1));

  always_comb begin
    bit_d  = bit_q;
    err_d  = err_q;
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    any_d  = any_q;
    berr_d = 1'b0;
    upd_d  = 1'b0;
    drop   = 1'b0;
    if (!in_sync) begin
      bit_d = '0;
      err_d = '0;
      ph_d  = '0;
      any_d = 1'b0;
    end else if (cmp_vld) begin
      if (ph_q == PH_W'(GROUP_BITS - 1)) begin
        berr_d = any_now;
        ph_d   = '0;
        any_d  = 1'b0;
      end else begin
        ph_d  = ph_q + PH_W'(1);
        any_d = any_now;
      end
      if (last_bit) begin
        cnt_d = err_sum;
        upd_d = 1'b1;
        bit_d = '0;
        err_d = '0;
        drop  = (err_sum > CNT_W'(ERR_LIMIT));
      end else begin
        bit_d = bit_q + BIT_W'(1);
        err_d = err_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      err_q  <= '0;
      cnt_q  <= '0;
      ph_q   <= '0;
      any_q  <= 1'b0;
      berr_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      err_q  <= err_d;
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      any_q  <= any_d;
      berr_q <= berr_d;
      upd_q  <= upd_d;
    end
  end

  assign byte_err  = berr_q;
  assign ber_upd   = upd_q;
  assign ber_count = cnt_q;

endmodule

// File: rtl/prbs11_bert.sv
module prbs11_bert
  import prbs11_bert_pkg::*;
#(
  parameter int CORR_LEN  = 24,
  parameter int SYNC_RUN  = 64,
  parameter int WIN_BITS  = 10000,
  parameter int ERR_LIMIT = 2000,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic             sync,
  output logic             seq_start,
  output logic             byte_err,
  output logic             ber_upd,
  output logic [CNT_W-1:0] ber_count
);

  logic in_sync;
  logic cmp_vld;
  logic cmp_err;
  logic drop;

  prbs11_start_corr #(.CORR_LEN(CORR_LEN)) corr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .hit     (seq_start)
  );

  prbs11_lock_ctrl #(.SYNC_RUN(SYNC_RUN)) lock_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .drop    (drop),
    .in_sync (in_sync),
    .cmp_vld (cmp_vld),
    .cmp_err (cmp_err)
  );

  prbs11_err_meter #(
    .WIN_BITS  (WIN_BITS),
    .ERR_LIMIT (ERR_LIMIT),
    .CNT_W     (CNT_W)
  ) meter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_sync   (in_sync),
    .cmp_vld   (cmp_vld),
    .cmp_err   (cmp_err),
    .drop      (drop),
    .byte_err  (byte_err),
    .ber_upd   (ber_upd),
    .ber_count (ber_count)
  );

  assign sync = in_sync;

endmodule

// File: rtl/prbs11_bert_chk.sv
module prbs11_bert_chk #(
  parameter int WIN_BITS  = 10000,
  parameter int ERR_LIMIT = 2000,
  parameter int CNT_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_vld,
  input logic             sync,
  input logic             seq_start,
  input logic             byte_err,
  input logic             ber_upd,
  input logic [CNT_W-1:0] ber_count
);

  assert_upd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ber_upd |=> !ber_upd);

  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ber_upd |-> ber_count == $past(ber_count));

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ber_count) <= WIN_BITS);

  assert_byte_in_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_err |-> $past(sync));

  assert_drop_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync) |-> (ber_upd && (32'(ber_count) > ERR_LIMIT)));

  assert_lock_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(bit_vld));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> (!ber_upd && !byte_err && !seq_start));

endmodule

bind prbs11_bert prbs11_bert_chk #(
  .WIN_BITS  (WIN_BITS),
  .ERR_LIMIT (ERR_LIMIT),
  .CNT_W     (CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_vld   (bit_vld),
  .sync      (sync),
  .seq_start (seq_start),
  .byte_err  (byte_err),
  .ber_upd   (ber_upd),
  .ber_count (ber_count)
);

// File: tb/prbs11_bert_tb_top.sv
module prbs11_bert_tb_top;

  localparam int CL    = 24;
  localparam int RUN   = 64;
  localparam int WIN   = 10000;
  localparam int LIMIT = 2000;

  logic        clk;
  logic        rst_n;
  logic        bit_vld;
  logic        bit_in;
  logic        sync;
  logic        seq_start;
  logic        byte_err;
  logic        ber_upd;
  logic [15:0] ber_count;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench-side expectations
  logic [10:0]   tx_s;
  logic [10:0]   mh;
  logic [CL-1:0] m_corr;
  logic [CL-1:0] ref_pat;
  int  m_run, m_win, m_werr, m_ph;
  bit  m_any;
  bit  e_sync, e_byte, e_upd, e_start;
  int  e_cnt;
  int  mm_sync, mm_byte, mm_upd, mm_cnt, mm_start, mm_idle;
  int  n_start, n_byte, n_upd;

  prbs11_bert #(
    .CORR_LEN(CL), .SYNC_RUN(RUN), .WIN_BITS(WIN), .ERR_LIMIT(LIMIT), .CNT_W(16)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .sync(sync), .seq_start(seq_start), .byte_err(byte_err),
    .ber_upd(ber_upd), .ber_count(ber_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void clear_mm();
    mm_sync = 0; mm_byte = 0; mm_upd = 0; mm_cnt = 0; mm_start = 0; mm_idle = 0;
    n_start = 0; n_byte = 0; n_upd = 0;
  endfunction

  function automatic logic tx_next();
    logic b;
    b = tx_s[10] ^ tx_s[8];
    tx_s = {tx_s[9:0], b};
    return b;
  endfunction

  function automatic void model_bit(input logic b);
    logic pred;
    bit   e;
    e_upd = 0;
    e_byte = 0;
    m_corr = {m_corr[CL-2:0], b};
    e_start = (m_corr == ref_pat);
    pred = mh[10] ^ mh[8];
    if (!e_sync) begin
      mh = {mh[9:0], b};
      if ((mh[10:1] != 0 || 1'b0) || 1'b1) begin end
      if (({pred} == b) && (m_hist_nonzero())) begin
        if (m_run == RUN - 1) begin
          e_sync = 1; m_run = 0; m_win = 0; m_werr = 0; m_ph = 0; m_any = 0;
        end else m_run++;
      end else m_run = 0;
      m_prev_upd();
    end else begin
      e = (b != pred);
      mh = {mh[9:0], pred};
      m_any = m_any | e;
      m_ph++;
      if (m_ph == 8) begin e_byte = m_any; m_ph = 0; m_any = 0; end
      m_werr += int'(e);
      m_win++;
      if (m_win == WIN) begin
        e_upd = 1; e_cnt = m_werr;
        if (m_werr > LIMIT) begin e_sync = 0; m_run = 0; end
        m_win = 0; m_werr = 0;
      end
    end
  endfunction

  // history before the current bit was shifted in; kept separately for the hunt rule
  logic [10:0] mh_prev;
  function automatic bit m_hist_nonzero();
    return mh_prev != 0;
  endfunction
  function automatic void m_prev_upd();
    mh_prev = mh;
  endfunction

  task automatic compare_outputs();
    if (sync !== e_sync) mm_sync++;
    if (byte_err !== e_byte) mm_byte++;
    if (ber_upd !== e_upd) mm_upd++;
    if (int'(ber_count) != e_cnt) mm_cnt++;
    if (seq_start !== e_start) mm_start++;
    if (seq_start === 1'b1) n_start++;
    if (byte_err === 1'b1) n_byte++;
    if (ber_upd === 1'b1) n_upd++;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = b;
    mh_prev = mh;
    model_bit(b);
    @(posedge clk);
    #1;
    compare_outputs();
  endtask

  task automatic send_idle();
    @(negedge clk);
    bit_vld = 1'b0;
    bit_in  = 1'b1;
    @(posedge clk);
    #1;
    if (byte_err !== 1'b0 || ber_upd !== 1'b0 || seq_start !== 1'b0) mm_idle++;
    if (sync !== e_sync || int'(ber_count) != e_cnt) mm_idle++;
  endtask

  function automatic bit sparse_hit(input int w);
    return (w == 10) || (w == 20) || (w == 21) || (w == 100) ||
           (w == 1000) || (w == 5000) || (w == 9000);
  endfunction

  // mode 0 clean, 1 sparse, else error every `mode` bits; gaps insert idles
  task automatic run_window(input int mode, input bit gaps);
    bit fin = 0;
    int k = 0;
    while (!fin) begin
      logic b;
      bit inj;
      b = tx_next();
      inj = 0;
      if (mode == 1) inj = sparse_hit(m_win);
      else if (mode > 1) inj = ((m_win % mode) == 0);
      send_bit(b ^ inj);
      fin = e_upd;
      k++;
      if (gaps && (k % 50) == 0) send_idle();
    end
  endtask

  task automatic test_reset();
    clear_mm();
    check(sync == 1'b0, "R10 sync after reset", int'(sync), 0);
    check(seq_start == 1'b0, "R10 seq_start after reset", int'(seq_start), 0);
    check(byte_err == 1'b0, "R10 byte_err after reset", int'(byte_err), 0);
    check(ber_upd == 1'b0, "R10 ber_upd after reset", int'(ber_upd), 0);
    check(ber_count == 16'd0, "R10 ber_count after reset", int'(ber_count), 0);
  endtask

  task automatic test_zero_stream();
    clear_mm();
    for (int i = 0; i < 300; i++) send_bit(1'b0);
    check(sync == 1'b0, "R4 all-zero stream must not lock", int'(sync), 0);
    check(mm_sync == 0, "R4 sync track during zeros", mm_sync, 0);
  endtask

  task automatic test_acquire();
    int guard = 0;
    int exp_start = 0;
    clear_mm();
    tx_s = '1;
    while (!e_sync && guard < 400) begin
      send_bit(tx_next());
      if (e_start) exp_start++;
      guard++;
    end
    check(n_start == exp_start && exp_start >= 1, "R2 seq_start pulse count", n_start, exp_start);
    check(mm_start == 0, "R2 seq_start timing", mm_start, 0);
    check(sync == 1'b1, "R3 lock after 64 matches", int'(sync), 1);
    check(mm_sync == 0, "R3 lock cycle", mm_sync, 0);
  endtask

  task automatic test_clean_window_gaps();
    clear_mm();
    run_window(0, 1);
    check(mm_idle == 0, "R9 idle cycles advance nothing", mm_idle, 0);
    check(n_upd == 1 && mm_upd == 0, "R7 one update strobe", n_upd, 1);
    check(ber_count == 16'd0, "R1 clean PRBS-11 gives no errors", int'(ber_count), 0);
    check(n_byte == 0, "R6 no byte errors on clean data", n_byte, 0);
  endtask

  task automatic test_sparse_errors();
    clear_mm();
    run_window(1, 0);
    check(ber_count == 16'd7, "R5 each flipped bit counted once", int'(ber_count), 7);
    check(n_byte == 6 && mm_byte == 0, "R6 byte_err per erroneous group", n_byte, 6);
    check(mm_cnt == 0 && mm_upd == 0, "R7 count and strobe timing", mm_cnt + mm_upd, 0);
    check(sync == 1'b1, "R5 lock kept with few errors", int'(sync), 1);
  endtask

  task automatic test_limit_exact();
    clear_mm();
    run_window(5, 0);
    check(ber_count == 16'd2000, "R8 window total at limit", int'(ber_count), 2000);
    check(sync == 1'b1, "R8 exactly 2000 errors keeps lock", int'(sync), 1);
  endtask

  task automatic test_limit_over();
    clear_mm();
    run_window(4, 0);
    check(ber_count == 16'd2500, "R7 window total above limit", int'(ber_count), 2500);
    check(sync == 1'b0, "R8 over 2000 errors drops lock", int'(sync), 0);
    check(mm_sync == 0 && mm_byte == 0, "R8 drop timing and byte flags", mm_sync + mm_byte, 0);
  endtask

  task automatic test_reacquire();
    int guard = 0;
    clear_mm();
    while (!e_sync && guard < 500) begin
      send_bit(tx_next());
      guard++;
    end
    for (int i = 0; i < 40; i++) send_bit(tx_next());
    check(sync == 1'b1, "R3 re-lock after loss", int'(sync), 1);
    check(mm_sync == 0 && mm_byte == 0, "R3 re-lock timing", mm_sync + mm_byte, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [10:0] s;
    s = '1;
    for (int i = 0; i < CL; i++) begin
      logic b;
      b = s[10] ^ s[8];
      s = {s[9:0], b};
      ref_pat[CL-1-i] = b;
    end
    mh = '0; mh_prev = '0; m_corr = '0; tx_s = '1;
    m_run = 0; m_win = 0; m_werr = 0; m_ph = 0; m_any = 0;
    e_sync = 0; e_byte = 0; e_upd = 0; e_start = 0; e_cnt = 0;
    rst_n = 1'b0;
    bit_vld = 1'b0;
    bit_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    test_zero_stream();
    test_acquire();
    test_clean_window_gaps();
    test_sparse_errors();
    test_limit_exact();
    test_limit_over();
    test_reacquire();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule